// File: doc/BRIEF.md
# Packed SIMD Sign-Apply Unit

This unit takes a packed data vector and a packed control vector of up to 256 bits. It splits both vectors into signed lanes of 8, 16 or 32 bits. Each output lane depends on the sign of the control lane at the same position. A negative control lane gives the two's-complement negation of the data lane. A zero control lane gives zero. A positive control lane passes the data lane through unchanged.

An active-length select limits processing to the low 64, 128 or 256 bits. A mode input decides what happens to the bits above that length and where the data comes from:

- **Legacy (two-operand) mode:** the previous destination value arrives on `merge_i`. It is both the data source and the fill value for the bits above the active length.
- **Three-operand mode:** the data comes from `data_i`, and every bit above the active length is cleared.

The unit is a single registered stage with a pulse handshake and no back-pressure. A legal request produces a result and `out_valid_o` one clock later. A request with an illegal configuration raises `illegal_o` one clock later instead and leaves the result register untouched.

Top module: `sign_apply_unit`

## Requirements
- R1: In a lane whose control value (read as signed) is negative, the result lane is the two's-complement negation of the data lane, `(0 - data) mod 2^W`.
- R2: In a lane whose control value is exactly zero, the result lane is zero.
- R3: In a lane whose control value is positive, the result lane equals the data lane.
- R4: `esize_i` selects the lane width: 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. Lane k covers bits `[k*W +: W]` of both operands. The value 3 is illegal.
- R5: `vlen_i` selects the active length: 0 selects 64 bits, 1 selects 128 bits and 2 selects 256 bits. The value 3 (both length bits set) is an inconsistent encoding and is illegal.
- R6: With `three_op_i` = 0 (legacy mode), the data lanes are taken from `merge_i` and `data_i` has no effect. Result bits at or above the active length equal `merge_i`.
- R7: With `three_op_i` = 1, the data lanes are taken from `data_i`. Result bits at or above the active length are zero.
- R8: A request is illegal if any of the following holds:
  - `esize_i` = 3;
  - `vlen_i` = 3;
  - three-operand mode with a 64-bit length;
  - legacy mode with a 256-bit length.

  For an illegal request, `illegal_o` pulses one clock after `in_valid_i`, `out_valid_o` stays low and `result_o` keeps its previous value.
- R9: For a legal request, `out_valid_o` pulses and `result_o` updates exactly one clock after `in_valid_i`. Without `in_valid_i`, `out_valid_o` and `illegal_o` stay low and `result_o` holds. Reset clears `out_valid_o`, `illegal_o` and `result_o`.
- R10: Negating the most negative lane value (0x80, 0x8000 or 0x80000000) returns the same bit pattern, with no saturation and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe, one cycle per operation |
| three_op_i | input | 1 | 1 = three-operand mode, 0 = legacy merge mode |
| esize_i | input | 2 | Lane width select |
| vlen_i | input | 2 | Active vector length select |
| data_i | input | 256 | Data operand (three-operand mode) |
| ctrl_i | input | 256 | Control operand whose lane signs steer the result |
| merge_i | input | 256 | Previous destination value (data and fill in legacy mode) |
| out_valid_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Illegal configuration strobe |
| result_o | output | 256 | Registered result vector |

## Verification
The assertions assume that all configuration and operand inputs are stable and known during any cycle in which `in_valid_i` is high. They also assume that `merge_i` is held across the edge that captures a legacy request, so that the preserved upper bits can be compared against its past value.

The bench changes every input only on the falling clock edge, so each request is presented whole for a full cycle. It mixes directed corner cases with seeded pseudo-random requests:

- The directed cases cover the most negative lane values and control words whose sign differs between byte and word views.
- They also cover each illegal combination, followed by idle cycles.
- The random requests draw every field, including the reserved codes, and bias control lanes toward zero.

// File: rtl/sign_apply_pkg.sv
package sign_apply_pkg;
  typedef enum logic [1:0] {
    ESZ_8   = 2'd0,
    ESZ_16  = 2'd1,
    ESZ_32  = 2'd2,
    ESZ_RSV = 2'd3
  } esize_e;

  typedef enum logic [1:0] {
    VLEN_64  = 2'd0,
    VLEN_128 = 2'd1,
    VLEN_256 = 2'd2,
    VLEN_RSV = 2'd3
  } vlen_e;

  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/sign_lane.sv
module sign_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] ctrl_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    if (ctrl_i == '0)       res_o = '0;
    else if (ctrl_i[W-1])   res_o = ~data_i + W'(1);
    else                    res_o = data_i;
  end

  always_comb begin
    if (ctrl_i == '0) begin
      a_r2_zero_lane: assert (res_o == '0);
    end else if (ctrl_i[W-1]) begin
      a_r1_neg_sum: assert (W'(res_o + data_i) == '0);
    end else begin
      a_r3_pass_lane: assert (res_o == data_i);
    end
  end
endmodule

// File: rtl/sign_cfg_check.sv
module sign_cfg_check
  import sign_apply_pkg::*;
(
  input  logic [1:0] esize_i,
  input  logic [1:0] vlen_i,
  input  logic       three_op_i,
  output logic       legal_o
);
  esize_e esz;
  vlen_e  vl;
  logic   len_ok;

  assign esz = esize_e'(esize_i);
  assign vl  = vlen_e'(vlen_i);

  always_comb begin
    unique case (vl)
      VLEN_64:  len_ok = !three_op_i;
      VLEN_128: len_ok = 1'b1;
      VLEN_256: len_ok = three_op_i;
      default:  len_ok = 1'b0;
    endcase
  end

  assign legal_o = len_ok && (esz != ESZ_RSV);

  always_comb begin
    if (three_op_i && vlen_i == 2'd0) begin
      a_r8_short_three_op: assert (!legal_o);
    end
    if (!three_op_i && vlen_i == 2'd2) begin
      a_r8_long_legacy: assert (!legal_o);
    end
  end
endmodule

// File: rtl/sign_vec_core.sv
module sign_vec_core
  import sign_apply_pkg::*;
#(
  parameter int unsigned MAX_W = 256
) (
  input  logic [1:0]       esize_i,
  input  logic [1:0]       vlen_i,
  input  logic             three_op_i,
  input  logic [MAX_W-1:0] data_i,
  input  logic [MAX_W-1:0] ctrl_i,
  input  logic [MAX_W-1:0] merge_i,
  output logic [MAX_W-1:0] res_o
);
  localparam int unsigned QTR_W  = MAX_W / 4;
  localparam int unsigned HALF_W = MAX_W / 2;

  logic [MAX_W-1:0]                src;
  logic [MAX_W-1:0]                fill;
  logic [MAX_W-1:0]                mask;
  logic [MAX_W-1:0]                sel;
  logic [NUM_SIZES-1:0][MAX_W-1:0] by_size;
  int unsigned                     act_w;

  // legacy mode: destination doubles as data source
  assign src  = three_op_i ? data_i : merge_i;
  assign fill = three_op_i ? '0     : merge_i;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int unsigned LW = 8 << s;
    localparam int unsigned NL = MAX_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      sign_lane #(.W(LW)) u_lane (
        .data_i (src[l*LW +: LW]),
        .ctrl_i (ctrl_i[l*LW +: LW]),
        .res_o  (by_size[s][l*LW +: LW])
      );
    end
  end

  always_comb begin
    unique case (esize_e'(esize_i))
      ESZ_16:  sel = by_size[1];
      ESZ_32:  sel = by_size[2];
      default: sel = by_size[0];
    endcase
  end

  always_comb begin
    unique case (vlen_e'(vlen_i))
      VLEN_64:  act_w = QTR_W;
      VLEN_128: act_w = HALF_W;
      default:  act_w = MAX_W;
    endcase
    for (int i = 0; i < MAX_W; i++) mask[i] = (i < act_w);
  end

  assign res_o = (sel & mask) | (fill & ~mask);
endmodule

// File: rtl/sign_apply_unit.sv
module sign_apply_unit
  import sign_apply_pkg::*;
#(
  parameter int unsigned MAX_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             three_op_i,
  input  logic [1:0]       esize_i,
  input  logic [1:0]       vlen_i,
  input  logic [MAX_W-1:0] data_i,
  input  logic [MAX_W-1:0] ctrl_i,
  input  logic [MAX_W-1:0] merge_i,
  output logic             out_valid_o,
  output logic             illegal_o,
  output logic [MAX_W-1:0] result_o
);
  localparam int unsigned HALF_W = MAX_W / 2;

  logic             legal;
  logic [MAX_W-1:0] core_res;
  logic             valid_q;
  logic             ill_q;
  logic [MAX_W-1:0] res_q;

  sign_cfg_check u_cfg (
    .esize_i    (esize_i),
    .vlen_i     (vlen_i),
    .three_op_i (three_op_i),
    .legal_o    (legal)
  );

  sign_vec_core #(.MAX_W(MAX_W)) u_core (
    .esize_i    (esize_i),
    .vlen_i     (vlen_i),
    .three_op_i (three_op_i),
    .data_i     (data_i),
    .ctrl_i     (ctrl_i),
    .merge_i    (merge_i),
    .res_o      (core_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid_i && legal;
      ill_q   <= in_valid_i && !legal;
      if (in_valid_i && legal) res_q <= core_res;
    end
  end

  assign out_valid_o = valid_q;
  assign illegal_o   = ill_q;
  assign result_o    = res_q;

  a_r9_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && legal) |=> out_valid_o);

  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || illegal_o) |-> $past(in_valid_i));

  a_r8_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!out_valid_o && $stable(result_o)));

  a_r7_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && legal && three_op_i) |=> (result_o[MAX_W-1:HALF_W] == '0 || $past(vlen_i) == 2'd2));

  a_r6_upper_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && legal && !three_op_i) |=> (result_o[MAX_W-1:HALF_W] == $past(merge_i[MAX_W-1:HALF_W])));
endmodule

// File: tb/sim_sign_apply_unit.sv
module sim_sign_apply_unit;
  typedef struct {
    bit           v;
    bit           il;
    logic [255:0] r;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic         three_op = 1'b0;
  logic [1:0]   esize = 2'd0;
  logic [1:0]   vlen = 2'd1;
  logic [255:0] data = '0;
  logic [255:0] ctrl = '0;
  logic [255:0] merge = '0;
  logic         out_valid;
  logic         illegal;
  logic [255:0] result;

  exp_t         q[$];
  logic [255:0] last_res = '0;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  sign_apply_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .three_op_i(three_op),
    .esize_i(esize), .vlen_i(vlen), .data_i(data), .ctrl_i(ctrl), .merge_i(merge),
    .out_valid_o(out_valid), .illegal_o(illegal), .result_o(result)
  );

  function automatic bit is_legal(int esz, int vl, bit top);
    if (esz > 2 || vl > 2) return 1'b0;
    if (top) return vl != 0;
    return vl != 2;
  endfunction

  function automatic logic [255:0] model(int esz, int vl, bit top,
                                         logic [255:0] d, logic [255:0] c, logic [255:0] m);
    int w;
    int act;
    logic [255:0] src;
    logic [255:0] res;
    w   = 8 << esz;
    act = 64 << vl;
    src = top ? d : m;
    res = top ? '0 : m;
    for (int e = 0; e < act / w; e++) begin
      logic [31:0] de, ce, re, msk;
      msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      de  = 32'(src >> (e * w)) & msk;
      ce  = 32'(c >> (e * w)) & msk;
      if (ce == 0)          re = 32'd0;
      else if (ce[w-1])     re = (32'd0 - de) & msk;
      else                  re = de;
      for (int b = 0; b < w; b++) res[e*w + b] = re[b];
    end
    return res;
  endfunction

  task automatic op(string tag, int esz, int vl, bit top,
                    logic [255:0] d, logic [255:0] c, logic [255:0] m);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1;
    esize = 2'(esz);
    vlen = 2'(vl);
    three_op = top;
    data = d;
    ctrl = c;
    merge = m;
    x.tag = tag;
    if (is_legal(esz, vl, top)) begin
      last_res = model(esz, vl, top, d, c, m);
      x.v = 1'b1;
      x.il = 1'b0;
    end else begin
      x.v = 1'b0;
      x.il = 1'b1;
    end
    x.r = last_res;
    q.push_back(x);
  endtask

  task automatic idle(string tag);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b0;
    data = {8{$urandom}};
    ctrl = {8{$urandom}};
    x.v = 1'b0;
    x.il = 1'b0;
    x.r = last_res;
    x.tag = tag;
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_chk++;
      if (out_valid !== x.v || illegal !== x.il || result !== x.r) begin
        n_bad++;
        $display("FAIL %s: valid=%0b illegal=%0b result=%h expected valid=%0b illegal=%0b result=%h",
                 x.tag, out_valid, illegal, result, x.v, x.il, x.r);
      end
    end
  end

  function automatic logic [255:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [255:0] rnd_ctrl();
    logic [255:0] c;
    c = rnd_vec();
    for (int k = 0; k < 32; k++) if ($urandom % 3 == 0) c[k*8 +: 8] = 8'h00;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] pat;
    pat = 256'h0123456789ABCDEF_FEDCBA9876543210_1122334455667788_99AABBCCDDEEFF00;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_chk++;
    if (out_valid !== 1'b0 || illegal !== 1'b0 || result !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: valid=%0b illegal=%0b result=%h expected 0 0 0",
               out_valid, illegal, result);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    op("R1 neg bytes", 0, 1, 1'b0, '0, {32{8'hFF}}, pat);
    op("R2 zero ctrl", 0, 1, 1'b0, '0, '0, pat);
    op("R3 pos ctrl", 0, 1, 1'b0, '0, {32{8'h01}}, pat);
    op("R10 min byte", 0, 1, 1'b1, {32{8'h80}}, {32{8'hC0}}, pat);
    op("R10 min word", 1, 2, 1'b1, {16{16'h8000}}, {16{16'h9000}}, pat);
    op("R10 min dword", 2, 2, 1'b1, {8{32'h8000_0000}}, {8{32'hF000_0000}}, pat);
    op("R4 byte view", 0, 2, 1'b1, pat, {16{16'h00FF}}, '0);
    op("R4 word view", 1, 2, 1'b1, pat, {16{16'h00FF}}, '0);
    op("R4 dword view", 2, 2, 1'b1, pat, {8{32'h0000_FF00}}, '0);
    idle("R9 hold");
    op("R5 len64 legacy", 1, 0, 1'b0, '0, {16{16'hFFFF}}, pat);
    op("R5 len256", 2, 2, 1'b1, pat, {4{64'h8000_0000_0000_0001}}, {256{1'b1}});
    op("R6 data ignored a", 0, 1, 1'b0, {256{1'b1}}, {32{8'h85}}, pat);
    op("R6 data ignored b", 0, 1, 1'b0, '0, {32{8'h85}}, pat);
    op("R7 upper zero", 1, 1, 1'b1, pat, {16{16'h7FFF}}, {256{1'b1}});
    op("R8 three-op len64", 0, 0, 1'b1, pat, pat, pat);
    idle("R8 held");
    op("R8 legacy len256", 0, 2, 1'b0, pat, pat, pat);
    op("R8 len rsv", 1, 3, 1'b1, pat, pat, pat);
    op("R8 esize rsv", 3, 1, 1'b0, pat, pat, pat);
    idle("R8 held");
    op("R9 after illegal", 2, 1, 1'b0, '0, pat, ~pat);

    for (int n = 0; n < 300; n++) begin
      int esz, vl;
      bit top;
      esz = (($urandom % 8) == 0) ? 3 : int'($urandom % 3);
      vl  = (($urandom % 8) == 0) ? 3 : int'($urandom % 3);
      top = 1'($urandom);
      if ($urandom % 5 == 0) idle("R9 gap");
      else if (!is_legal(esz, vl, top)) op("R8 random", esz, vl, top, rnd_vec(), rnd_ctrl(), rnd_vec());
      else if (top) op("R7 random", esz, vl, top, rnd_vec(), rnd_ctrl(), rnd_vec());
      else op("R6 random", esz, vl, top, rnd_vec(), rnd_ctrl(), rnd_vec());
    end

    idle("R9 tail");
    @(negedge clk);
    in_valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule